// File: doc/BRIEF.md
# SPI Memory Status-Register Controller

This block is the command and status logic of a serial-peripheral-interface memory slave. A host drives chip select, serial clock and serial data in; the block decodes the first byte of each frame as an instruction. It can return the status byte, write the protection bits, or set and clear the write-enable latch. A successful status write starts an internal write-cycle timer. The write-in-progress bit follows that timer, and the latch is cleared when the timer finishes.

All serial pins are brought into the system clock domain through a synchronizer and sampled there. Data in is taken on rising serial-clock edges and data out changes on falling edges (SPI mode 0). The serial output is only driven while a status read is returning data. At all other times the output-enable is low. The array itself and its commands are outside this block. The block-protect bits are plain registers.

Top module: `spi_status_ctrl`

## Requirements
- R1: After reset the status byte is 0x00, `miso_oe` is 0 and `busy` is 0.
- R2: Status layout: bit 7 protect-enable, bits 6..4 read 0, bit 3 block-protect 1, bit 2 block-protect 0, bit 1 write-enable latch, bit 0 write-in-progress. Opcode 0x05 reads it: `miso_oe` stays 0 during serial clocks 0..7, then the byte is driven MSB first and the host samples it on rising clocks 8..15.
- R3: While chip select stays low after a 0x05 opcode, the current status byte is sent again every 8 serial clocks.
- R4: Opcode 0x06 sets the latch and opcode 0x04 clears it when chip select rises, whatever the protection bits and `wp_n` hold.
- R5: Opcode 0x01 followed by a data byte copies data bits 7, 3 and 2 into status bits 7, 3 and 2 when chip select rises. Data bits 6..4, 1 and 0 have no effect.
- R6: Opcode 0x01 has no effect while the latch is 0.
- R7: Opcode 0x01 has no effect while status bit 7 is 1 and `wp_n` is 0.
- R8: An accepted status write holds `busy` and status bit 0 at 1 for exactly WRITE_CYCLES clock cycles. When they drop, the latch is cleared in the same cycle, so no status byte ever shows one of bits 1 and 0 set without the other at the end of the cycle.
- R9: While `busy` is 1, opcode 0x05 still works and opcodes 0x01, 0x06 and 0x04 have no effect.
- R10: Any other opcode is ignored and `miso_oe` stays 0 for the whole frame.
- R11: Raising chip select sets `miso_oe` to 0 and restarts the bit count, so a partial byte does not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for `miso` (0 = high impedance) |
| busy | output | 1 | Internal write cycle running |

## Verification
The end of a write cycle and the load of a status byte for a repeated read can land in the same system-clock cycle. The timer clears write-in-progress and the latch at that moment, while the shifter snapshots the byte. The bench provokes this by starting a status write, then holding chip select low on a continuous status read that spans the end of the timer, so one of the byte loads meets the drop. Every byte returned must show bits 1 and 0 either both set or both clear, and the last byte must be the settled value.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;

    localparam int BYTE_BITS = 8;

    localparam logic [7:0] OPC_READ_STAT  = 8'h05;
    localparam logic [7:0] OPC_WRITE_STAT = 8'h01;
    localparam logic [7:0] OPC_LATCH_SET  = 8'h06;
    localparam logic [7:0] OPC_LATCH_CLR  = 8'h04;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_READ_STAT,
        CMD_WRITE_STAT,
        CMD_LATCH_SET,
        CMD_LATCH_CLR
    } cmd_e;

    // Stored status state; write-in-progress comes from the timer
    typedef struct packed {
        logic prot_en;
        logic blk1;
        logic blk0;
        logic wr_latch;
    } stat_state_t;

    // One received byte from the serial link
    typedef struct packed {
        logic       valid;
        logic       first;
        logic [7:0] data;
    } rx_byte_t;

    function automatic cmd_e decode_opcode(input logic [7:0] op);
        cmd_e c;
        case (op)
            OPC_READ_STAT:  c = CMD_READ_STAT;
            OPC_WRITE_STAT: c = CMD_WRITE_STAT;
            OPC_LATCH_SET:  c = CMD_LATCH_SET;
            OPC_LATCH_CLR:  c = CMD_LATCH_CLR;
            default:        c = CMD_NONE;
        endcase
        return c;
    endfunction

    function automatic logic [7:0] pack_status(input stat_state_t s, input logic wip);
        return {s.prot_en, 3'b000, s.blk1, s.blk0, s.wr_latch, wip};
    endfunction

    // bits = {new prot_en, new blk1, new blk0}; latch is untouched
    function automatic stat_state_t apply_status_write(input stat_state_t s,
                                                       input logic [2:0] bits);
        stat_state_t n;
        n          = s;
        n.prot_en  = bits[2];
        n.blk1     = bits[1];
        n.blk0     = bits[0];
        return n;
    endfunction

endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/spi_sr_link.sv
module spi_sr_link
    import spi_sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_s,
    input  logic       sck_s,
    input  logic       mosi_s,
    input  logic       tx_en,
    input  logic [7:0] tx_byte,
    output rx_byte_t   rx,
    output logic       cs_rise,
    output logic       miso,
    output logic       miso_oe
);
    localparam int BW = $clog2(BYTE_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_BITS - 1);

    logic                 sck_q, cs_q;
    logic                 sck_rise, sck_fall;
    logic [BW-1:0]        bit_cnt;
    logic [BYTE_BITS-1:0] rx_sr;
    logic                 op_done;
    logic [BYTE_BITS-1:0] tx_sr;
    logic                 miso_q, oe_q;
    rx_byte_t             rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_s;
        end
    end

    assign sck_rise = ~cs_s &  sck_s & ~sck_q;
    assign sck_fall = ~cs_s & ~sck_s &  sck_q;
    assign cs_rise  =  cs_s & ~cs_q;

    // Receive path: rising edges
    always_ff @(posedge clk) begin
        if (rst || cs_s) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            op_done <= 1'b0;
            rx_q    <= '0;
        end else begin
            rx_q.valid <= 1'b0;
            if (sck_rise) begin
                rx_sr   <= {rx_sr[BYTE_BITS-2:0], mosi_s};
                bit_cnt <= bit_cnt + BW'(1);
                if (bit_cnt == LAST_BIT) begin
                    rx_q.valid <= 1'b1;
                    rx_q.first <= ~op_done;
                    rx_q.data  <= {rx_sr[BYTE_BITS-2:0], mosi_s};
                    op_done    <= 1'b1;
                end
            end
        end
    end

    // Transmit path: falling edges, byte snapshot at each boundary
    always_ff @(posedge clk) begin
        if (rst || cs_s) begin
            tx_sr  <= '0;
            miso_q <= 1'b0;
            oe_q   <= 1'b0;
        end else if (sck_fall && tx_en) begin
            oe_q <= 1'b1;
            if (bit_cnt == '0) begin
                miso_q <= tx_byte[BYTE_BITS-1];
                tx_sr  <= {tx_byte[BYTE_BITS-2:0], 1'b0};
            end else begin
                miso_q <= tx_sr[BYTE_BITS-1];
                tx_sr  <= {tx_sr[BYTE_BITS-2:0], 1'b0};
            end
        end
    end

    assign rx      = rx_q;
    assign miso    = miso_q;
    assign miso_oe = oe_q;

    p_quiet_deselected_r11: assert property (@(posedge clk) disable iff (rst)
        cs_s |=> !oe_q);

    p_no_drive_in_opcode_r2: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> op_done);
endmodule

// File: rtl/spi_sr_wtimer.sv
module spi_sr_wtimer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          busy_q;

    assign done = busy_q && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt    <= '0;
        end else if (busy_q) begin
            if (done) busy_q <= 1'b0;
            else      cnt    <= cnt + CW'(1);
        end
    end

    assign busy = busy_q;

    p_start_only_idle_r9: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);
endmodule

// File: rtl/spi_sr_regs.sv
module spi_sr_regs
    import spi_sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rx_byte_t   rx,
    input  logic       cs_rise,
    input  logic       wp_n,
    input  logic       busy,
    input  logic       done,
    output logic       tx_en,
    output logic [7:0] tx_byte,
    output logic       start
);
    stat_state_t st;
    cmd_e        cmd;
    logic [2:0]  wbits;
    logic        have_data;
    logic        run;
    logic        pin_block;

    assign run       = cs_rise & ~busy;
    assign pin_block = st.prot_en & ~wp_n;
    assign start     = run && (cmd == CMD_WRITE_STAT) && have_data
                       && st.wr_latch && !pin_block;

    // Frame capture
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd       <= CMD_NONE;
            wbits     <= '0;
            have_data <= 1'b0;
        end else if (cs_rise) begin
            cmd       <= CMD_NONE;
            have_data <= 1'b0;
        end else if (rx.valid) begin
            if (rx.first) begin
                cmd <= decode_opcode(rx.data);
            end else if (!have_data) begin
                wbits     <= {rx.data[7], rx.data[3], rx.data[2]};
                have_data <= 1'b1;
            end
        end
    end

    // Status state update at frame end or write-cycle end
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (done) begin
            st.wr_latch <= 1'b0;
        end else if (run) begin
            case (cmd)
                CMD_LATCH_SET:  st.wr_latch <= 1'b1;
                CMD_LATCH_CLR:  st.wr_latch <= 1'b0;
                CMD_WRITE_STAT: if (start) st <= apply_status_write(st, wbits);
                default: ;
            endcase
        end
    end

    assign tx_en   = (cmd == CMD_READ_STAT);
    assign tx_byte = pack_status(st, busy);

    p_write_needs_latch_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(st.wr_latch));

    p_write_obeys_pin_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !($past(st.prot_en) && !$past(wp_n)));

    p_latch_drops_with_wip_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !st.wr_latch);

    p_prot_frozen_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable({st.prot_en, st.blk1, st.blk0}));
endmodule

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl
    import spi_sr_pkg::*;
#(
    parameter int WRITE_CYCLES = 5000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic wp_n,
    output logic miso,
    output logic miso_oe,
    output logic busy
);
    logic [2:0] pins_s;
    rx_byte_t   rx;
    logic       cs_rise;
    logic       tx_en;
    logic [7:0] tx_byte;
    logic       start;
    logic       done;

    spi_sr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({cs_n, sck, mosi}),
        .dout (pins_s)
    );

    spi_sr_link u_link (
        .clk     (clk),
        .rst     (rst),
        .cs_s    (pins_s[2]),
        .sck_s   (pins_s[1]),
        .mosi_s  (pins_s[0]),
        .tx_en   (tx_en),
        .tx_byte (tx_byte),
        .rx      (rx),
        .cs_rise (cs_rise),
        .miso    (miso),
        .miso_oe (miso_oe)
    );

    spi_sr_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .rx      (rx),
        .cs_rise (cs_rise),
        .wp_n    (wp_n),
        .busy    (busy),
        .done    (done),
        .tx_en   (tx_en),
        .tx_byte (tx_byte),
        .start   (start)
    );

    spi_sr_wtimer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .done  (done)
    );
endmodule

// File: tb/sim_spi_status_ctrl.sv
module sim_spi_status_ctrl;
    localparam int W    = 3000;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic miso, miso_oe, busy;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    spi_status_ctrl #(.WRITE_CYCLES(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe), .busy(busy)
    );

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] dat;
        logic       wpn;
        logic [7:0] now;
        logic [7:0] after;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{8'h06, 8'h00, 1'b1, 8'h02, 8'h02},  // R4 set latch
        '{8'h04, 8'h00, 1'b1, 8'h00, 8'h00},  // R4 clear latch
        '{8'h01, 8'h8C, 1'b1, 8'h00, 8'h00},  // R6 write without latch
        '{8'h06, 8'h00, 1'b1, 8'h02, 8'h02},  // R4
        '{8'h01, 8'hFF, 1'b1, 8'h8F, 8'h8C},  // R5 masked bits, R8
        '{8'h06, 8'h00, 1'b0, 8'h8E, 8'h8E},  // R4 latch set while protected
        '{8'h01, 8'h00, 1'b0, 8'h8E, 8'h8E},  // R7 pin blocks write
        '{8'h01, 8'h00, 1'b1, 8'h03, 8'h00},  // R5 pin released
        '{8'h9F, 8'h00, 1'b1, 8'h00, 8'h00},  // R10 unknown opcode
        '{8'h06, 8'h00, 1'b1, 8'h02, 8'h02},  // R4
        '{8'h01, 8'h04, 1'b1, 8'h07, 8'h04}   // R5
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk8(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic chk32(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rxb,
                            output logic oe_any, output logic oe_all);
        oe_any = 1'b0;
        oe_all = 1'b1;
        rxb    = '0;
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            tick(HALF);
            rxb[i] = miso;
            if (miso_oe === 1'b1) oe_any = 1'b1; else oe_all = 1'b0;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cs_on();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic cs_off();
        tick(HALF);
        cs_n = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic read_stat(output logic [7:0] s);
        logic [7:0] d;
        logic a, l;
        cs_on();
        spi_byte(8'h05, d, a, l);
        chk8("R2", "oe during opcode clocks", {7'd0, a}, 8'h00);
        spi_byte(8'h00, s, a, l);
        chk8("R2", "oe during data clocks", {7'd0, l}, 8'h01);
        cs_off();
        chk8("R11", "oe after deselect", {7'd0, miso_oe}, 8'h00);
    endtask

    task automatic frame2(input logic [7:0] op, input logic [7:0] dat);
        logic [7:0] d;
        logic a, l;
        cs_on();
        spi_byte(op, d, a, l);
        spi_byte(dat, d, a, l);
        chk8("R10", "no drive on non-read frame", {7'd0, a}, 8'h00);
        cs_off();
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 2 * W && busy; g++) tick(1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL R8 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] s, b, d;
        logic a, l;
        int cnt;
        bit seen_end;

        tick(5);
        rst = 1'b0;
        tick(5);

        // R1 reset state
        chk8("R1", "miso_oe after reset", {7'd0, miso_oe}, 8'h00);
        chk8("R1", "busy after reset", {7'd0, busy}, 8'h00);
        read_stat(s);
        chk8("R1", "status after reset", s, 8'h00);

        // Vector table: R4 R5 R6 R7 R10
        for (int v = 0; v < NV; v++) begin
            wp_n = VECS[v].wpn;
            frame2(VECS[v].op, VECS[v].dat);
            read_stat(s);
            chk8("table", $sformatf("row %0d status now", v), s, VECS[v].now);
            wait_idle();
            read_stat(s);
            chk8("table", $sformatf("row %0d status settled", v), s, VECS[v].after);
            wp_n = 1'b1;
        end

        // R3 repeated status bytes while selected
        cs_on();
        spi_byte(8'h05, d, a, l);
        for (int k = 0; k < 3; k++) begin
            spi_byte(8'h00, b, a, l);
            chk8("R3", $sformatf("repeat byte %0d", k), b, 8'h04);
        end
        cs_off();

        // R8 exact write-cycle length
        frame2(8'h06, 8'h00);
        cs_on();
        spi_byte(8'h01, d, a, l);
        spi_byte(8'h08, d, a, l);
        tick(HALF);
        cs_n = 1'b1;
        cnt = 0;
        for (int c = 0; c < W + 100; c++) begin
            tick(1);
            if (busy) cnt++;
        end
        chk32("R8", "busy cycle count", cnt, W);
        read_stat(s);
        chk8("R8", "status after write cycle", s, 8'h08);

        // R9 commands during a write cycle
        frame2(8'h06, 8'h00);
        frame2(8'h01, 8'h80);
        read_stat(s);
        chk8("R9", "read during write", s, 8'h83);
        frame2(8'h04, 8'h00);
        read_stat(s);
        chk8("R9", "latch clear ignored while busy", s, 8'h83);
        frame2(8'h01, 8'h0C);
        read_stat(s);
        chk8("R9", "status write ignored while busy", s, 8'h83);

        // R8 end of write cycle meeting a repeated byte load
        seen_end = 0;
        cs_on();
        spi_byte(8'h05, d, a, l);
        for (int k = 0; k < 60 && !seen_end; k++) begin
            spi_byte(8'h00, b, a, l);
            if (b != 8'h83) chk8("R8", "coherent byte at cycle end", b, 8'h80);
            if (b == 8'h80) seen_end = 1;
        end
        cs_off();
        chk8("R8", "end of cycle observed", {7'd0, seen_end}, 8'h01);
        read_stat(s);
        chk8("R8", "settled after cycle", s, 8'h80);

        // R11 partial byte then a full frame
        cs_on();
        for (int i = 0; i < 3; i++) begin
            mosi = 1'b1;
            tick(HALF);
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
        cs_off();
        chk8("R11", "oe after aborted frame", {7'd0, miso_oe}, 8'h00);
        frame2(8'h06, 8'h00);
        read_stat(s);
        chk8("R11", "frame after partial byte", s, 8'h82);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule